// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block is a small fully associative address translation buffer. Software stages a tag word and a translation word through a shared write port, and then strobes a load. The staged pair is copied into the entry named by a victim pointer. A combinational lookup port takes a virtual address and returns a hit flag, the translated physical address and the page attributes of the winning entry.

A lock register holds two fields: a base index and the victim pointer. After each load the pointer advances by one. When it passes the last entry it wraps back to the base, so entries below the base are never chosen for replacement. Each entry also carries a preserved bit. Preserved entries survive a global flush, but a targeted flush can still remove them. A targeted flush matches on the tag and the page size held in the staged tag word.

Top module: `lockable_tlb`

## Requirements
- R1: After reset no lookup hits and `lock_o` reads zero.
- R2: A load copies the staged tag word and the staged translation word into the entry selected by the victim pointer. The tag word holds the virtual tag in bits 31:12, the size code in 1:0, valid in bit 2 and preserved in bit 3. The translation word holds the physical page in 31:12, endianism in bit 9, element size in 8:7 and mixed-size select in bit 6. A lookup that matches the entry returns these attributes.
- R3: Size codes are 0 = 1 MB, 1 = 64 KB, 2 = 4 KB and 3 = 16 MB. Only the address bits above the page size are compared. The physical address is the entry's page bits above the page size joined with the lookup address bits below it.
- R4: On a miss, `hit_o` is low and `pa_o` and all attribute outputs are zero. An entry loaded with the valid bit clear never hits.
- R5: A lock write sets the base index from data bits 15:10 and the victim pointer from bits 9:4. `lock_o` returns them in the same positions, with all other bits zero.
- R6: Each load advances the victim pointer by one. A load at the last entry (N_ENTRIES-1) moves the pointer to the base index instead.
- R7: A targeted flush invalidates every valid entry whose size code equals the staged size code and whose tag matches the staged tag above that page size, including preserved entries. Entries that do not match keep their state.
- R8: A global flush invalidates all entries except those with the preserved bit set.
- R9: When several valid entries match a lookup, the one with the lowest index supplies the result.
- R10: When a load falls in the same cycle as a flush, the flush acts on the contents before that cycle, and the newly loaded entry ends up valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wdata_i | input | 32 | Shared write data for the staging and lock writes |
| cam_wr_i | input | 1 | Write `wdata_i` into the staged tag word |
| ram_wr_i | input | 1 | Write `wdata_i` into the staged translation word |
| lock_wr_i | input | 1 | Write `wdata_i` into the lock register |
| load_i | input | 1 | Copy the staged words into the victim entry |
| flush_entry_i | input | 1 | Targeted flush using the staged tag word |
| flush_all_i | input | 1 | Global flush of non-preserved entries |
| lock_o | output | 32 | Lock register readback |
| va_i | input | 32 | Lookup virtual address |
| hit_o | output | 1 | Lookup hit |
| pa_o | output | 32 | Translated physical address |
| endian_o | output | 1 | Endianism attribute |
| elem_size_o | output | 2 | Element size attribute |
| mixed_o | output | 1 | Mixed-size select attribute |

## Verification
A load can fall in the same cycle as either kind of flush. The bench drives both strobes together in a single cycle. In the first case the load comes with a global flush, and the bench checks that an older non-preserved entry is gone while the new one hits. In the second case the load comes with a targeted flush whose staged tag equals an entry already present. The bench then checks that the lookup returns the new translation from the next victim slot, and that the victim pointer moved exactly once.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WORD_W       = 32;
  localparam int LOCK_FLD_W   = 6;
  localparam int CAM_VALID    = 2;
  localparam int CAM_PRES     = 3;
  localparam int RAM_ENDIAN   = 9;
  localparam int RAM_ES_LSB   = 7;
  localparam int RAM_MIXED    = 6;
  localparam int LOCK_BASE_LSB = 10;
  localparam int LOCK_VIC_LSB  = 4;

  typedef enum logic [1:0] {
    PG_1M   = 2'd0,
    PG_64K  = 2'd1,
    PG_4K   = 2'd2,
    PG_16M  = 2'd3
  } pg_size_e;

  function automatic logic [WORD_W-1:0] size_mask(input logic [1:0] code);
    case (pg_size_e'(code))
      PG_1M:   size_mask = 32'hFFF0_0000;
      PG_64K:  size_mask = 32'hFFFF_0000;
      PG_4K:   size_mask = 32'hFFFF_F000;
      default: size_mask = 32'hFF00_0000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              flush_sel_i,
  input  logic              flush_all_i,
  input  logic [WORD_W-1:0] stage_cam_i,
  input  logic [WORD_W-1:0] stage_ram_i,
  input  logic [WORD_W-1:0] va_i,
  output logic              match_o,
  output logic [1:0]        size_o,
  output logic [WORD_W-1:0] ram_o
);
  logic [WORD_W-1:0] cam_q, ram_q, mask;
  logic valid, pres, flush_hit;

  assign valid = cam_q[CAM_VALID];
  assign pres  = cam_q[CAM_PRES];
  assign mask  = size_mask(cam_q[1:0]);
  assign flush_hit = valid && (stage_cam_i[1:0] == cam_q[1:0]) &&
                     (((stage_cam_i ^ cam_q) & mask) == '0);
  assign match_o = valid && (((va_i ^ cam_q) & mask) == '0);
  assign size_o  = cam_q[1:0];
  assign ram_o   = ram_q;

  // load wins over flushes; flushes see pre-cycle contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cam_q <= '0;
      ram_q <= '0;
    end else if (load_i) begin
      cam_q <= stage_cam_i;
      ram_q <= stage_ram_i;
    end else if ((flush_sel_i && flush_hit) || (flush_all_i && !pres)) begin
      cam_q[CAM_VALID] <= 1'b0;
    end
  end

  // R7
  flush_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_sel_i && flush_hit && !load_i) |=> !cam_q[CAM_VALID]);

  // R8
  keep_preserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !flush_sel_i && !load_i && valid && pres) |=> cam_q[CAM_VALID]);
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lock_wr_i,
  input  logic [LOCK_FLD_W-1:0] base_wr_i,
  input  logic [LOCK_FLD_W-1:0] vic_wr_i,
  input  logic                  load_i,
  output logic [LOCK_FLD_W-1:0] base_o,
  output logic [LOCK_FLD_W-1:0] victim_o
);
  localparam logic [LOCK_FLD_W-1:0] LAST = LOCK_FLD_W'(N_ENTRIES - 1);
  logic [LOCK_FLD_W-1:0] base_q, vic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      vic_q  <= '0;
    end else if (lock_wr_i) begin
      base_q <= base_wr_i;
      vic_q  <= vic_wr_i;
    end else if (load_i) begin
      vic_q <= (vic_q >= LAST) ? base_q : vic_q + 1'b1;
    end
  end

  assign base_o   = base_q;
  assign victim_o = vic_q;

  // R6
  vic_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !lock_wr_i && vic_q < LAST) |=> vic_q == $past(vic_q) + 1'b1);

  // R6
  vic_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !lock_wr_i && vic_q == LAST) |=> vic_q == $past(base_q));
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N_ENTRIES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] match_i,
  output logic [N_ENTRIES-1:0] grant_o,
  output logic                 hit_o
);
  always_comb begin
    grant_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) grant_o = N_ENTRIES'(1) << i;
    end
  end
  assign hit_o = |grant_o;

  // R9
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (hit_o == |match_i));

  // R9
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((grant_o - 1'b1) & match_i) == '0));
endmodule

// File: rtl/lockable_tlb.sv
module lockable_tlb
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] wdata_i,
  input  logic        cam_wr_i,
  input  logic        ram_wr_i,
  input  logic        lock_wr_i,
  input  logic        load_i,
  input  logic        flush_entry_i,
  input  logic        flush_all_i,
  output logic [31:0] lock_o,
  input  logic [31:0] va_i,
  output logic        hit_o,
  output logic [31:0] pa_o,
  output logic        endian_o,
  output logic [1:0]  elem_size_o,
  output logic        mixed_o
);
  logic [WORD_W-1:0] stage_cam_q, stage_ram_q;
  logic [LOCK_FLD_W-1:0] base, victim;
  logic [N_ENTRIES-1:0] match, grant;
  logic [WORD_W-1:0] ram_w [N_ENTRIES];
  logic [1:0] size_w [N_ENTRIES];
  logic [WORD_W-1:0] sel_ram, sel_mask;
  logic [1:0] sel_size;
  logic hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_cam_q <= '0;
      stage_ram_q <= '0;
    end else begin
      if (cam_wr_i) stage_cam_q <= wdata_i;
      if (ram_wr_i) stage_ram_q <= wdata_i;
    end
  end

  tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk_i, .rst_ni,
    .lock_wr_i,
    .base_wr_i (wdata_i[LOCK_BASE_LSB +: LOCK_FLD_W]),
    .vic_wr_i  (wdata_i[LOCK_VIC_LSB +: LOCK_FLD_W]),
    .load_i,
    .base_o    (base),
    .victim_o  (victim)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    tlb_entry u_ent (
      .clk_i, .rst_ni,
      .load_i      (load_i && (victim == LOCK_FLD_W'(g))),
      .flush_sel_i (flush_entry_i),
      .flush_all_i,
      .stage_cam_i (stage_cam_q),
      .stage_ram_i (stage_ram_q),
      .va_i,
      .match_o     (match[g]),
      .size_o      (size_w[g]),
      .ram_o       (ram_w[g])
    );
  end

  tlb_prio #(.N_ENTRIES(N_ENTRIES)) u_prio (
    .clk_i, .rst_ni,
    .match_i (match),
    .grant_o (grant),
    .hit_o   (hit)
  );

  always_comb begin
    sel_ram  = '0;
    sel_size = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (grant[i]) begin
        sel_ram  = sel_ram | ram_w[i];
        sel_size = sel_size | size_w[i];
      end
    end
  end

  assign sel_mask    = size_mask(sel_size);
  assign hit_o       = hit;
  assign pa_o        = hit ? ((sel_ram & sel_mask) | (va_i & ~sel_mask)) : '0;
  assign endian_o    = hit & sel_ram[RAM_ENDIAN];
  assign elem_size_o = hit ? sel_ram[RAM_ES_LSB +: 2] : 2'b00;
  assign mixed_o     = hit & sel_ram[RAM_MIXED];
  assign lock_o      = {16'h0, base, victim, 4'h0};

  // R4
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0 && !endian_o && elem_size_o == 2'b00 && !mixed_o));
endmodule

// File: tb/tb_lockable_tlb.sv
module tb_lockable_tlb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] wdata = '0;
  logic cam_wr = 0, ram_wr = 0, lock_wr = 0, load = 0, fl_ent = 0, fl_all = 0;
  logic [31:0] va = '0;
  logic [31:0] lock_o, pa;
  logic hit, endian, mixed;
  logic [1:0] es;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lockable_tlb #(.N_ENTRIES(32)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wdata_i(wdata),
    .cam_wr_i(cam_wr), .ram_wr_i(ram_wr), .lock_wr_i(lock_wr),
    .load_i(load), .flush_entry_i(fl_ent), .flush_all_i(fl_all),
    .lock_o(lock_o), .va_i(va), .hit_o(hit), .pa_o(pa),
    .endian_o(endian), .elem_size_o(es), .mixed_o(mixed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
  endtask

  task automatic strobe(input bit c, input bit r, input bit lk, input bit ld,
                        input bit fe, input bit fa, input logic [31:0] d);
    @(negedge clk);
    wdata = d; cam_wr = c; ram_wr = r; lock_wr = lk; load = ld; fl_ent = fe; fl_all = fa;
    @(negedge clk);
    cam_wr = 0; ram_wr = 0; lock_wr = 0; load = 0; fl_ent = 0; fl_all = 0;
  endtask

  task automatic put(input logic [31:0] cam, input logic [31:0] ram);
    strobe(1, 0, 0, 0, 0, 0, cam);
    strobe(0, 1, 0, 0, 0, 0, ram);
    strobe(0, 0, 0, 1, 0, 0, '0);
  endtask

  task automatic look(input string req, input logic [31:0] a,
                      input bit exp_hit, input logic [31:0] exp_pa);
    @(negedge clk); va = a; #1;
    chk(req, {31'b0, hit}, {31'b0, exp_hit});
    chk(req, pa, exp_pa);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 lock", lock_o, 32'h0);
    look("R1 miss", 32'h0000_0000, 0, 32'h0);
  endtask

  task automatic t_load_basic();
    do_reset();
    put(32'h1234_5006, 32'hABCD_E340);
    look("R2", 32'h1234_5678, 1, 32'hABCD_E678);
    chk("R2 attr", {28'b0, endian, es, mixed}, {28'b0, 1'b1, 2'd2, 1'b1});
    chk("R6 step", lock_o, 32'h0000_0010);
  endtask

  task automatic t_sizes();
    do_reset();
    put(32'h4000_0004, 32'h8000_0000);
    put(32'h5001_0005, 32'h9002_0000);
    put(32'h6012_3007, 32'hA100_0000);
    look("R3 1MB", 32'h400A_BCDE, 1, 32'h800A_BCDE);
    look("R3 1MB out", 32'h4010_0000, 0, 32'h0);
    look("R3 64KB", 32'h5001_FFFF, 1, 32'h9002_FFFF);
    look("R3 16MB", 32'h60FE_DCBA, 1, 32'hA1FE_DCBA);
  endtask

  task automatic t_invalid();
    do_reset();
    put(32'h7000_0002, 32'h1234_5340);
    look("R4 invalid", 32'h7000_0000, 0, 32'h0);
    chk("R4 attr", {29'b0, endian, es}, 32'h0);
  endtask

  task automatic t_lock_wrap();
    do_reset();
    strobe(0, 0, 1, 0, 0, 0, (32'd4 << 10) | (32'd30 << 4));
    chk("R5 readback", lock_o, 32'h0000_11E0);
    put(32'h0100_0006, 32'h0);
    chk("R6 to last", lock_o, 32'h0000_11F0);
    put(32'h0200_0006, 32'h0);
    chk("R6 wrap", lock_o, 32'h0000_1040);
  endtask

  task automatic t_flush_entry();
    do_reset();
    put(32'h1111_100E, 32'hC000_0000);
    put(32'h2222_2006, 32'hD000_0000);
    strobe(1, 0, 0, 0, 0, 0, 32'h2222_2001);
    strobe(0, 0, 0, 0, 1, 0, '0);
    look("R7 size differs", 32'h2222_2000, 1, 32'hD000_0000);
    strobe(1, 0, 0, 0, 0, 0, 32'h1111_1002);
    strobe(0, 0, 0, 0, 1, 0, '0);
    look("R7 preserved gone", 32'h1111_1000, 0, 32'h0);
    look("R7 other kept", 32'h2222_2010, 1, 32'hD000_0010);
  endtask

  task automatic t_flush_all();
    do_reset();
    put(32'h1111_100E, 32'hC000_0000);
    put(32'h2222_2006, 32'hD000_0000);
    strobe(0, 0, 0, 0, 0, 1, '0);
    look("R8 preserved kept", 32'h1111_1004, 1, 32'hC000_0004);
    look("R8 plain gone", 32'h2222_2000, 0, 32'h0);
  endtask

  task automatic t_priority();
    do_reset();
    strobe(0, 0, 1, 0, 0, 0, 32'd5 << 4);
    put(32'h3333_3006, 32'h5555_5000);
    strobe(0, 0, 1, 0, 0, 0, 32'd2 << 4);
    put(32'h3333_3006, 32'h6666_6000);
    look("R9 lowest", 32'h3333_3123, 1, 32'h6666_6123);
  endtask

  task automatic t_same_cycle();
    do_reset();
    put(32'h4444_4006, 32'hE000_0000);
    strobe(1, 0, 0, 0, 0, 0, 32'h7777_7006);
    strobe(0, 1, 0, 0, 0, 0, 32'h8888_8000);
    strobe(0, 0, 0, 1, 0, 1, '0);
    look("R10 old flushed", 32'h4444_4000, 0, 32'h0);
    look("R10 new kept", 32'h7777_7000, 1, 32'h8888_8000);
    do_reset();
    put(32'h7777_7006, 32'h1100_0000);
    strobe(0, 1, 0, 0, 0, 0, 32'h2200_0000);
    strobe(0, 0, 0, 1, 1, 0, '0);
    look("R10 load+flush entry", 32'h7777_7ABC, 1, 32'h2200_0ABC);
    chk("R10 victim", lock_o, 32'h0000_0020);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_basic();
    t_sizes();
    t_invalid();
    t_lock_wrap();
    t_flush_entry();
    t_flush_all();
    t_priority();
    t_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule